// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges three reset requests into a single system reset: an active-low power-on input, a brown-out comparator flag that counts only while the brown-out enable is set, and a one-cycle watchdog timeout pulse. While any request is active the system reset stays asserted. Once every request has gone quiet, a programmable start-up count runs so that the clock can settle. A two-stage release chain then de-asserts the reset on a clock edge.

A second output keeps the I/O registers in their reset state, which leaves the pins as high-impedance inputs. It covers the whole system reset and releases one cycle after it, so the pins are not enabled while the core is still leaving reset. A sticky two-bit field records which source started the most recent reset, and it can be read after release. The brown-out enable is a one-bit register. Only power-on clears it, so it survives the brown-out and watchdog resets it takes part in.

Top module: `rstseq_top`

## Requirements
- R1: A low level on `por_n` asserts `sys_rst` and `io_reset` at once, without waiting for a clock edge, and holds both while `por_n` stays low.
- R2: A `wdt_pulse` sampled high on a rising clock edge makes `sys_rst` high after that edge.
- R3: `bo_flag` causes a reset only while `bo_en` is 1. With `bo_en` at 0 a high `bo_flag` leaves `sys_rst` low. With `bo_en` at 1, `sys_rst` stays high for as long as `bo_flag` stays high.
- R4: Power-on clears `bo_en` to 0. A clock edge with `bo_en_we` high loads `bo_en_wdata`. Brown-out and watchdog resets leave `bo_en` unchanged.
- R5: `sys_rst` falls exactly START_CYCLES+2 rising edges after the last edge at which any source was sampled active (default START_CYCLES = 16).
- R6: A source that re-asserts during the start-up count restarts that count from zero.
- R7: `io_reset` is high whenever `sys_rst` is high, and it falls exactly one cycle after `sys_rst` falls.
- R8: `rst_cause` is updated on each edge that samples an active source. The encoding is 2'b01 for power-on, 2'b10 for brown-out and 2'b11 for watchdog, with priority power-on > brown-out > watchdog. It holds its value on every other edge and never reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Power-on reset request, active low, asynchronous |
| bo_flag | input | 1 | Brown-out comparator output, 1 = supply below threshold, synchronous to clk |
| bo_en_we | input | 1 | Write strobe for the brown-out enable bit |
| bo_en_wdata | input | 1 | Value loaded into the brown-out enable bit |
| wdt_pulse | input | 1 | Watchdog timeout, one-cycle pulse |
| sys_rst | output | 1 | System reset, active high |
| io_reset | output | 1 | Forces I/O registers to reset (pins high-impedance inputs), active high |
| rst_cause | output | 2 | Source of the last reset: 01 power-on, 10 brown-out, 11 watchdog |
| bo_en | output | 1 | Current brown-out enable bit |

## Verification
On every edge out of power-on, the assertions check the following. A watchdog pulse or an enabled brown-out forces reset on the next cycle. The I/O reset always covers the system reset and trails it by one cycle. The cause field never reads zero, changes only when a source is sampled, and reports the watchdog when that source is alone. Release never directly follows a sampled request. The exact release distance, the restart of the count, the masking of a disabled brown-out, the asynchronous power-on assertion and the survival of the enable bit across resets can only be shown by the bench scenarios, which compare against the cycle model.

// File: rtl/rstseq_pkg.sv
// Package: shared types of the reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rstseq_pkg;

    // Encoded source of the most recent reset; zero is never produced.
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_POR   = 2'b01,
        CAUSE_BROWN = 2'b10,
        CAUSE_WDOG  = 2'b11
    } rst_cause_e;

endpackage

// File: rtl/rstseq_src.sv
// Module: rstseq_src
// Merges the reset sources into one hold request. Owns the brown-out
// enable bit and the sticky cause register.
// Assumes: bo_flag and wdt_pulse are synchronous to clk; por_n is held
// low for at least one clock edge whenever power-on is requested.
module rstseq_src
    import rstseq_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       bo_flag,
    input  logic       bo_en_we,
    input  logic       bo_en_wdata,
    input  logic       wdt_pulse,
    output logic       bo_en,
    output logic       hold,
    output rst_cause_e cause
);

    logic bo_en_q;
    logic bo_live;

    // Brown-out counts only while enabled.
    assign bo_live = bo_en_q & bo_flag;

    // Any active source requests reset.
    assign hold  = ~por_n | bo_live | wdt_pulse;
    assign bo_en = bo_en_q;

    // Enable bit: cleared only by power-on, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            bo_en_q <= 1'b0;
        end else if (bo_en_we) begin
            bo_en_q <= bo_en_wdata;
        end
    end

    // Sticky cause, priority power-on > brown-out > watchdog.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cause <= CAUSE_POR;
        end else if (bo_live) begin
            cause <= CAUSE_BROWN;
        end else if (wdt_pulse) begin
            cause <= CAUSE_WDOG;
        end
    end

endmodule

// File: rtl/rstseq_dly.sv
// Module: rstseq_dly
// Start-up delay counter. Counts cycles with no reset request and
// saturates at START_CYCLES; any request restarts it from zero.
// Assumes: START_CYCLES >= 1.
module rstseq_dly #(
    parameter int unsigned START_CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic hold,
    output logic done
);

    localparam int unsigned CW = $clog2(START_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(START_CYCLES);

    logic [CW-1:0] cnt;

    // Flags that the full quiet interval has elapsed.
    assign done = (cnt == LAST);

    // Quiet-cycle counter, restarted by any request.
    always_ff @(posedge clk) begin
        if (!por_n || hold) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rstseq_rel.sv
// Module: rstseq_rel
// Release chain. Asserts the reset asynchronously on power-on and on the
// next edge for a synchronous request. Releases through SYNC_STAGES
// flops after the delay completes. The I/O reset trails by one cycle.
// Assumes: SYNC_STAGES >= 2.
module rstseq_rel #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic hold,
    input  logic done,
    output logic sys_rst,
    output logic io_reset
);

    logic [SYNC_STAGES-1:0] stg;
    logic                   io_q;

    // Release shift chain: set by power-on or a request, else shifts.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stg <= '1;
        end else if (hold) begin
            stg <= '1;
        end else begin
            stg <= {stg[SYNC_STAGES-2:0], ~done};
        end
    end

    assign sys_rst = stg[SYNC_STAGES-1];

    // One-cycle trailing copy that keeps the I/O in reset longer.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            io_q <= 1'b1;
        end else begin
            io_q <= sys_rst;
        end
    end

    assign io_reset = sys_rst | io_q;

endmodule

// File: rtl/rstseq_top.sv
// Module: rstseq_top
// Multi-source reset sequencer top: source merge, start-up delay and
// release chain.
// Assumes: clk keeps running while any reset is requested.
module rstseq_top #(
    parameter int unsigned START_CYCLES = 16,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       bo_flag,
    input  logic       bo_en_we,
    input  logic       bo_en_wdata,
    input  logic       wdt_pulse,
    output logic       sys_rst,
    output logic       io_reset,
    output logic [1:0] rst_cause,
    output logic       bo_en
);

    import rstseq_pkg::*;

    logic       hold;
    logic       done;
    rst_cause_e cause;

    assign rst_cause = cause;

    rstseq_src u_src (
        .clk         (clk),
        .por_n       (por_n),
        .bo_flag     (bo_flag),
        .bo_en_we    (bo_en_we),
        .bo_en_wdata (bo_en_wdata),
        .wdt_pulse   (wdt_pulse),
        .bo_en       (bo_en),
        .hold        (hold),
        .cause       (cause)
    );

    rstseq_dly #(.START_CYCLES(START_CYCLES)) u_dly (
        .clk   (clk),
        .por_n (por_n),
        .hold  (hold),
        .done  (done)
    );

    rstseq_rel #(.SYNC_STAGES(SYNC_STAGES)) u_rel (
        .clk      (clk),
        .por_n    (por_n),
        .hold     (hold),
        .done     (done),
        .sys_rst  (sys_rst),
        .io_reset (io_reset)
    );

endmodule

// File: rtl/rstseq_chk.sv
// Module: rstseq_chk
// Assertion checker for rstseq_top, attached with bind. It observes
// ports only.
// Assumes: clocked checks are disabled while por_n is low.
module rstseq_chk (
    input logic       clk,
    input logic       por_n,
    input logic       bo_flag,
    input logic       bo_en,
    input logic       wdt_pulse,
    input logic       sys_rst,
    input logic       io_reset,
    input logic [1:0] rst_cause
);

    p_wdt_asserts_r2: assert property (@(posedge clk) disable iff (!por_n)
        wdt_pulse |=> sys_rst);

    p_bo_holds_r3: assert property (@(posedge clk) disable iff (!por_n)
        (bo_en && bo_flag) |=> sys_rst);

    p_no_release_after_req_r5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> $past(!wdt_pulse && !(bo_en && bo_flag)));

    p_io_covers_r7: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |-> io_reset);

    p_io_trails_r7: assert property (@(posedge clk) disable iff (!por_n)
        $fell(io_reset) |-> (!sys_rst && $past(!sys_rst)));

    p_cause_legal_r8: assert property (@(posedge clk) disable iff (!por_n)
        rst_cause != 2'b00);

    p_cause_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
        (!wdt_pulse && !(bo_en && bo_flag)) |=> $stable(rst_cause));

    p_cause_wdog_r8: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_pulse && !(bo_en && bo_flag)) |=> (rst_cause == 2'b11));

endmodule

bind rstseq_top rstseq_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .bo_flag   (bo_flag),
    .bo_en     (bo_en),
    .wdt_pulse (wdt_pulse),
    .sys_rst   (sys_rst),
    .io_reset  (io_reset),
    .rst_cause (rst_cause)
);

// File: tb/rstseq_top_tb_top.sv
// Bench for rstseq_top: a behavioural cycle model is compared on every
// falling edge, and directed scenarios check the requirements by name.
module rstseq_top_tb_top;

    localparam int D = 5;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       bo_flag = 1'b0;
    logic       bo_en_we = 1'b0;
    logic       bo_en_wdata = 1'b0;
    logic       wdt_pulse = 1'b0;
    logic       sys_rst;
    logic       io_reset;
    logic [1:0] rst_cause;
    logic       bo_en;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Reference model state.
    int   quiet = 0;
    int   m_cause = 1;
    logic m_boen = 1'b0;
    bit   model_ok = 1'b0;

    always #4 clk = ~clk;

    rstseq_top #(.START_CYCLES(D)) dut_i (
        .clk         (clk),
        .por_n       (por_n),
        .bo_flag     (bo_flag),
        .bo_en_we    (bo_en_we),
        .bo_en_wdata (bo_en_wdata),
        .wdt_pulse   (wdt_pulse),
        .sys_rst     (sys_rst),
        .io_reset    (io_reset),
        .rst_cause   (rst_cause),
        .bo_en       (bo_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Model: advance the reference state on each rising edge.
    always @(posedge clk) begin
        bit h;
        h = !por_n || (m_boen && bo_flag) || wdt_pulse;
        if (!por_n) m_cause = 1;
        else if (m_boen && bo_flag) m_cause = 2;
        else if (wdt_pulse) m_cause = 3;
        if (!por_n) m_boen = 1'b0;
        else if (bo_en_we) m_boen = bo_en_wdata;
        if (h) quiet = 0;
        else if (quiet < 1000) quiet++;
        if (!por_n) model_ok = 1'b1;
        cycles++;
        if (cycles > 20000) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // Compare all outputs to the model away from the active edge.
    always @(negedge clk) begin
        if (model_ok) begin
            chk("R5 sys_rst", int'(sys_rst), int'(!por_n || quiet < D + 2));
            chk("R7 io_reset", int'(io_reset), int'(!por_n || quiet < D + 3));
            chk("R8 rst_cause", int'(rst_cause), m_cause);
            chk("R4 bo_en", int'(bo_en), int'(m_boen));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // Power-on: reset state.
        cyc(4);
        chk("R1 reset state sys_rst", int'(sys_rst), 1);
        chk("R8 reset cause por", int'(rst_cause), 1);
        chk("R4 bo_en cleared", int'(bo_en), 0);
        por_n = 1'b1;
        cyc(D + 1);
        chk("R5 still held", int'(sys_rst), 1);
        cyc(1);
        chk("R5 released", int'(sys_rst), 0);
        chk("R7 io still held", int'(io_reset), 1);
        cyc(1);
        chk("R7 io released", int'(io_reset), 0);
        cyc(2);

        // Watchdog pulse.
        wdt_pulse = 1'b1;
        cyc(1);
        wdt_pulse = 1'b0;
        chk("R2 wdt asserts", int'(sys_rst), 1);
        chk("R8 cause wdog", int'(rst_cause), 3);
        cyc(D + 4);

        // Brown-out while disabled is ignored.
        bo_flag = 1'b1;
        cyc(6);
        chk("R3 masked brown-out", int'(sys_rst), 0);
        chk("R3 masked cause", int'(rst_cause), 3);
        bo_flag = 1'b0;

        // Enable brown-out, then hold it.
        bo_en_we = 1'b1; bo_en_wdata = 1'b1;
        cyc(1);
        bo_en_we = 1'b0;
        chk("R4 enable written", int'(bo_en), 1);
        bo_flag = 1'b1;
        cyc(12);
        chk("R3 held in brown-out", int'(sys_rst), 1);
        chk("R8 cause brown", int'(rst_cause), 2);
        bo_flag = 1'b0;
        cyc(D + 4);
        chk("R3 released after brown-out", int'(sys_rst), 0);
        chk("R4 enable kept", int'(bo_en), 1);

        // Restart of the count by a late watchdog pulse.
        wdt_pulse = 1'b1;
        cyc(1);
        wdt_pulse = 1'b0;
        cyc(3);
        wdt_pulse = 1'b1;
        cyc(1);
        wdt_pulse = 1'b0;
        cyc(D + 1);
        chk("R6 count restarted", int'(sys_rst), 1);
        cyc(1);
        chk("R6 release after restart", int'(sys_rst), 0);
        cyc(3);

        // Simultaneous brown-out and watchdog: brown-out wins.
        bo_flag = 1'b1; wdt_pulse = 1'b1;
        cyc(1);
        bo_flag = 1'b0; wdt_pulse = 1'b0;
        chk("R8 priority brown over wdog", int'(rst_cause), 2);
        cyc(D + 4);

        // Asynchronous power-on in mid-cycle.
        @(posedge clk);
        #2 por_n = 1'b0;
        #1;
        chk("R1 async sys_rst", int'(sys_rst), 1);
        chk("R1 async io_reset", int'(io_reset), 1);
        cyc(3);
        chk("R4 enable cleared by por", int'(bo_en), 0);
        chk("R8 cause por", int'(rst_cause), 1);
        por_n = 1'b1;
        cyc(D + 4);
        chk("R5 out of reset", int'(sys_rst), 0);
        finish_run();
    end

endmodule